// File: doc/BRIEF.md
# Grouped Priority Interrupt Resolver

The resolver watches a bank of interrupt lines. Each line holds an enable bit, a sticky pending bit and a 4-bit urgency field, where a smaller value is more urgent. From the lines that are both pending and enabled it picks one winner and reports the winner's line number and a valid flag. A run-time grouping setting splits every urgency field into an upper pre-emption part and a lower tie-break part. The stored fields are never rewritten when the grouping changes. Only the pre-emption part decides whether the winner may interrupt the handler that is running now.

Software drives a small command port. Each command writes one line's enable bit, sets or clears one line's pending bit, loads one line's urgency from a separate pre-emption value and tie-break value, or changes the grouping. A read port shows the enable, pending, active bits and urgency field of any chosen line, and it also shows the current grouping. The handler side tells the block when it takes the current winner and when a handler finishes. The block uses these two events to keep its per-line active bits.

Top module: `irq_prio_resolver`

## Requirements
- R1: After a synchronous reset, every enable, pending and active bit is 0, every urgency field is 0 and the grouping is 0. The outputs `win_valid`, `win_idx` and `preempt` are all 0.
- R2: The winner is the pending and enabled line with the smallest 4-bit urgency field. On equal fields the lower line number wins. `win_valid`, `win_idx` and `preempt` are registered and reflect the state one clock after it changes. `win_idx` is 0 when no line qualifies.
- R3: A line that is pending but disabled keeps its pending bit and never becomes the winner.
- R4: The command codes on `cfg_op` are as follows. Unused codes 5 to 7 change nothing.
  - 0: write the enable bit from `cfg_data[0]`.
  - 1: set pending.
  - 2: clear pending.
  - 3: load the urgency field.
  - 4: write the grouping from `cfg_data[2:0]`.
- R5: Command 3 takes the pre-emption value from `cfg_data[7:4]` and the tie-break value from `cfg_data[3:0]`. With grouping g, the low g bits of the pre-emption value fill the top g bits of the field. The low 4-g bits of the tie-break value fill the rest.
- R6: Grouping g is the number of pre-emption bits, and its legal range is 0 to 4. A write of 5, 6 or 7 leaves the grouping unchanged. Changing the grouping does not alter any stored urgency field.
- R7: When no line is active, `preempt` is 1 whenever `win_valid` is 1.
- R8: When lines are active, the active level is the smallest pre-emption part (upper g bits) among the active lines. `preempt` is 1 only if the winner's pre-emption part is strictly smaller than the active level. An equal part does not raise it.
- R9: With grouping 0, `preempt` stays 0 while any line is active.
- R10: A cycle with `ack_i` high and `win_valid` high marks the registered winner active and clears its pending bit. `ack_i` while `win_valid` is low has no effect. `done_i` clears the active bit of `done_line`.
- R11: A high level on `irq_i[i]` sets line i's pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | NUM_LINES | Hardware requests, each sets its line's pending bit |
| cfg_we | input | 1 | Command strobe |
| cfg_op | input | 3 | Command code |
| cfg_line | input | IDX_W | Line addressed by the command |
| cfg_data | input | 8 | Command data |
| rd_line | input | IDX_W | Line shown on the read port |
| rd_enable | output | 1 | Enable bit of rd_line |
| rd_pending | output | 1 | Pending bit of rd_line |
| rd_active | output | 1 | Active bit of rd_line |
| rd_prio | output | 4 | Stored urgency field of rd_line |
| rd_group | output | 3 | Current grouping |
| ack_i | input | 1 | Handler takes the current winner |
| done_i | input | 1 | Handler for done_line has finished |
| done_line | input | IDX_W | Line whose handler finished |
| win_valid | output | 1 | A winner exists |
| win_idx | output | IDX_W | Winning line |
| preempt | output | 1 | Winner may interrupt the active handler |

## Verification
The bench builds the block with the default of 16 lines. This lets it drive a request on the top line, 15, and check that this top line beats lower lines on urgency alone. It moves through groupings 0, 2 and 4 while one handler stays active. This shows the same stored fields giving a pre-empting winner under one split and a blocked winner under another. Equal pre-emption parts, rejected grouping codes and unused command codes are each driven on their own.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int PRIO_W = 4;
    localparam int GRP_W  = 3;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [GRP_W-1:0]  grp_t;

    localparam grp_t GRP_MAX = grp_t'(PRIO_W);

    typedef enum logic [2:0] {
        OP_ENABLE   = 3'd0,
        OP_PEND_SET = 3'd1,
        OP_PEND_CLR = 3'd2,
        OP_PRIO     = 3'd3,
        OP_GROUP    = 3'd4
    } cfg_op_e;

    // Bits of the field that form the pre-emption part for grouping g.
    function automatic prio_t pre_mask(grp_t g);
        return ~(prio_t'('1) >> g);
    endfunction

    // Pack a pre-emption value and a tie-break value into one field.
    function automatic prio_t encode_prio(grp_t g, prio_t pre, prio_t sub);
        prio_t sub_m;
        prio_t pre_s;
        sub_m = prio_t'('1) >> g;
        pre_s = prio_t'(pre << (PRIO_W - int'(g)));
        return pre_s | (sub & sub_m);
    endfunction
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_prio_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_LINES-1:0]         irq_i,
    input  logic                         cfg_we,
    input  logic [2:0]                   cfg_op,
    input  logic [IDX_W-1:0]             cfg_line,
    input  logic [7:0]                   cfg_data,
    input  logic                         ack_take,
    input  logic [IDX_W-1:0]             ack_line,
    input  logic                         done_i,
    input  logic [IDX_W-1:0]             done_line,
    output logic [NUM_LINES-1:0]         en_q,
    output logic [NUM_LINES-1:0]         pend_q,
    output logic [NUM_LINES-1:0]         act_q,
    output logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q,
    output grp_t                         grp_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
            act_q  <= '0;
            prio_q <= '0;
            grp_q  <= '0;
        end else begin
            if (ack_take) begin
                act_q[ack_line]  <= 1'b1;
                pend_q[ack_line] <= 1'b0;
            end
            if (done_i) begin
                act_q[done_line] <= 1'b0;
            end
            if (cfg_we) begin
                case (cfg_op)
                    OP_ENABLE:   en_q[cfg_line]   <= cfg_data[0];
                    OP_PEND_SET: pend_q[cfg_line] <= 1'b1;
                    OP_PEND_CLR: pend_q[cfg_line] <= 1'b0;
                    OP_PRIO:     prio_q[cfg_line] <= encode_prio(grp_q, cfg_data[7:4], cfg_data[3:0]);
                    OP_GROUP:    if (cfg_data[2:0] <= GRP_MAX) grp_q <= cfg_data[2:0];
                    default: ;
                endcase
            end
            for (int i = 0; i < NUM_LINES; i++) begin
                if (irq_i[i]) pend_q[i] <= 1'b1;
            end
        end
    end

    // R6: a grouping code above the legal range is rejected
    assert_group_reject_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_op == OP_GROUP && cfg_data[2:0] > GRP_MAX) |=> $stable(grp_q));

    // R10: taking the winner makes it active unless finished in the same cycle
    assert_ack_marks_active_R10: assert property (@(posedge clk) disable iff (rst)
        (ack_take && !(done_i && done_line == ack_line)) |=> act_q[$past(ack_line)]);

    // R10: finishing clears the active bit
    assert_done_clears_R10: assert property (@(posedge clk) disable iff (rst)
        done_i |=> !act_q[$past(done_line)]);

    // R11: a raised request line is pending in the next cycle
    assert_irq_sets_pending_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_i != '0) |=> ((pend_q & $past(irq_i)) == $past(irq_i)));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_prio_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0]             cand,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
    output logic                             any,
    output logic [IDX_W-1:0]                 idx,
    output prio_t                            best
);
    // Upper bits are pre-emption, lower bits tie-break, so comparing the
    // whole field orders both at once; strict compare keeps the lower line.
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '1;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (cand[i] && (!any || prio[i] < best)) begin
                any  = 1'b1;
                idx  = IDX_W'(i);
                best = prio[i];
            end
        end
    end
endmodule

// File: rtl/irq_prio_level.sv
module irq_prio_level
    import irq_prio_pkg::*;
#(
    parameter int NUM_LINES = 16
) (
    input  logic [NUM_LINES-1:0]             act,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
    input  grp_t                             grp,
    output logic                             act_any,
    output prio_t                            act_lvl
);
    prio_t mask;

    always_comb begin
        mask    = pre_mask(grp);
        act_any = 1'b0;
        act_lvl = '1;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (act[i] && (!act_any || (prio[i] & mask) < act_lvl)) begin
                act_any = 1'b1;
                act_lvl = prio[i] & mask;
            end
        end
    end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_i,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_op,
    input  logic [IDX_W-1:0]     cfg_line,
    input  logic [7:0]           cfg_data,
    input  logic [IDX_W-1:0]     rd_line,
    output logic                 rd_enable,
    output logic                 rd_pending,
    output logic                 rd_active,
    output logic [PRIO_W-1:0]    rd_prio,
    output logic [GRP_W-1:0]     rd_group,
    input  logic                 ack_i,
    input  logic                 done_i,
    input  logic [IDX_W-1:0]     done_line,
    output logic                 win_valid,
    output logic [IDX_W-1:0]     win_idx,
    output logic                 preempt
);
    logic [NUM_LINES-1:0]             en_q, pend_q, act_q, cand;
    logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;
    grp_t                             grp_q;
    logic                             arb_any, act_any, ack_take, preempt_n;
    logic [IDX_W-1:0]                 arb_idx;
    prio_t                            arb_best, act_lvl, win_pre;

    assign ack_take = ack_i && win_valid;

    irq_prio_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk, .rst, .irq_i, .cfg_we, .cfg_op, .cfg_line, .cfg_data,
        .ack_take, .ack_line(win_idx), .done_i, .done_line,
        .en_q, .pend_q, .act_q, .prio_q, .grp_q
    );

    assign cand = en_q & pend_q;

    irq_prio_arb #(.NUM_LINES(NUM_LINES)) u_arb (
        .cand, .prio(prio_q), .any(arb_any), .idx(arb_idx), .best(arb_best)
    );

    irq_prio_level #(.NUM_LINES(NUM_LINES)) u_level (
        .act(act_q), .prio(prio_q), .grp(grp_q), .act_any, .act_lvl
    );

    assign win_pre   = arb_best & pre_mask(grp_q);
    assign preempt_n = arb_any && (!act_any || (grp_q != '0 && win_pre < act_lvl));

    always_ff @(posedge clk) begin
        if (rst) begin
            win_valid <= 1'b0;
            win_idx   <= '0;
            preempt   <= 1'b0;
        end else begin
            win_valid <= arb_any;
            win_idx   <= arb_idx;
            preempt   <= preempt_n;
        end
    end

    assign rd_enable  = en_q[rd_line];
    assign rd_pending = pend_q[rd_line];
    assign rd_active  = act_q[rd_line];
    assign rd_prio    = prio_q[rd_line];
    assign rd_group   = grp_q;

    // R2: a qualifying line yields a valid winner one cycle later
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (cand != '0) |=> win_valid);

    // R3: with nothing pending and enabled there is no winner
    assert_no_winner_R3: assert property (@(posedge clk) disable iff (rst)
        (cand == '0) |=> !win_valid);

    // R7: idle handler side means any winner pre-empts
    assert_idle_preempt_R7: assert property (@(posedge clk) disable iff (rst)
        (cand != '0 && act_q == '0) |=> preempt);

    // R8: pre-empt is never raised without a winner
    assert_preempt_needs_win_R8: assert property (@(posedge clk) disable iff (rst)
        preempt |-> win_valid);

    // R9: zero pre-emption bits block pre-emption of an active handler
    assert_group0_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        (grp_q == '0 && act_q != '0) |=> !preempt);
endmodule

// File: tb/irq_prio_resolver_bench.sv
module irq_prio_resolver_bench;
    import irq_prio_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_i = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_op = '0;
    logic [IW-1:0] cfg_line = '0;
    logic [7:0]    cfg_data = '0;
    logic [IW-1:0] rd_line = '0;
    logic          rd_enable, rd_pending, rd_active;
    logic [3:0]    rd_prio;
    logic [2:0]    rd_group;
    logic          ack_i = 1'b0, done_i = 1'b0;
    logic [IW-1:0] done_line = '0;
    logic          win_valid, preempt;
    logic [IW-1:0] win_idx;

    irq_prio_resolver #(.NUM_LINES(N)) u_irq_prio_resolver (
        .clk, .rst, .irq_i, .cfg_we, .cfg_op, .cfg_line, .cfg_data,
        .rd_line, .rd_enable, .rd_pending, .rd_active, .rd_prio, .rd_group,
        .ack_i, .done_i, .done_line, .win_valid, .win_idx, .preempt
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct packed {
        logic          v;
        logic [IW-1:0] idx;
        logic          pe;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] op, input int line, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_op = op; cfg_line = IW'(line); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int line);
        rd_line = IW'(line);
        #1;
    endtask

    // Driver side of the scoreboard: wait for the registered result, push the expectation.
    task automatic expect_win(input string tag, input logic v, input int idx, input logic pe);
        exp_t e;
        @(negedge clk);
        e.v = v; e.idx = IW'(idx); e.pe = pe;
        tag_q.push_back(tag);
        exp_q.push_back(e);
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack_i = 1'b1;
        @(negedge clk); ack_i = 1'b0;
    endtask

    task automatic pulse_done(input int line);
        @(negedge clk); done_i = 1'b1; done_line = IW'(line);
        @(negedge clk); done_i = 1'b0;
    endtask

    task automatic pulse_irq(input int line);
        @(negedge clk); irq_i[line] = 1'b1;
        @(negedge clk); irq_i = '0;
    endtask

    // Monitor side of the scoreboard.
    initial begin : monitor
        exp_t  e;
        string t;
        forever begin
            wait (exp_q.size() != 0);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if ({win_valid, win_idx, preempt} !== e) begin
                n_fail++;
                $display("FAIL %s: got valid=%0d idx=%0d preempt=%0d expected valid=%0d idx=%0d preempt=%0d",
                         t, win_valid, win_idx, preempt, e.v, e.idx, e.pe);
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd(3);
        chk("R1 pending", rd_pending, 0);
        chk("R1 group", rd_group, 0);
        chk("R1 prio", rd_prio, 0);
        expect_win("R1 outputs", 0, 0, 0);
        // R10: ack without a winner does nothing
        pulse_ack();
        rd(0);
        chk("R10 ack ignored", rd_active, 0);

        // R5: grouping 0 keeps only the tie-break bits
        cfg(OP_PRIO, 5, 8'h39);
        rd(5); chk("R5 group0 field", rd_prio, 9);
        cfg(OP_GROUP, 0, 8'h02);
        rd(0); chk("R6 group write", rd_group, 2);
        cfg(OP_PRIO, 5, 8'h12);
        rd(5); chk("R5 group2 field", rd_prio, 6);
        cfg(OP_PRIO, 6, 8'h56);
        rd(6); chk("R5 truncation", rd_prio, 6);

        // R3: pending but disabled
        cfg(OP_PEND_SET, 5, 8'h00);
        rd(5); chk("R3 stays pending", rd_pending, 1);
        expect_win("R3 no winner", 0, 0, 0);

        // R2 and R7: enable makes it win, idle side pre-empts
        cfg(OP_ENABLE, 5, 8'h01);
        expect_win("R2 single", 1, 5, 1);
        cfg(OP_ENABLE, 6, 8'h01);
        cfg(OP_PEND_SET, 6, 8'h00);
        expect_win("R2 tie lower index", 1, 5, 1);
        cfg(OP_PRIO, 9, 8'h10);
        cfg(OP_ENABLE, 9, 8'h01);
        cfg(OP_PEND_SET, 9, 8'h00);
        expect_win("R2 more urgent", 1, 9, 1);

        // R10: take line 9
        pulse_ack();
        rd(9);
        chk("R10 active set", rd_active, 1);
        chk("R10 pending cleared", rd_pending, 0);
        // R8: equal pre-emption part (4 vs 4 under grouping 2)
        expect_win("R8 equal no preempt", 1, 5, 0);
        cfg(OP_PRIO, 2, 8'h03);
        cfg(OP_ENABLE, 2, 8'h01);
        cfg(OP_PEND_SET, 2, 8'h00);
        expect_win("R8 strict preempt", 1, 2, 1);

        // R9 and R6: grouping 0 blocks pre-emption, fields untouched
        cfg(OP_GROUP, 0, 8'h00);
        rd(2); chk("R6 field kept", rd_prio, 3);
        expect_win("R9 group0 blocked", 1, 2, 0);
        cfg(OP_GROUP, 0, 8'h06);
        rd(0); chk("R6 illegal group", rd_group, 0);

        // R8: grouping 4, field 3 against active 4
        cfg(OP_GROUP, 0, 8'h04);
        expect_win("R8 group4 preempt", 1, 2, 1);
        // R4: unused command code
        cfg(3'd5, 2, 8'h00);
        rd(2);
        chk("R4 unused op pending", rd_pending, 1);
        chk("R4 unused op enable", rd_enable, 1);

        // R3: disable keeps pending and loses
        cfg(OP_ENABLE, 2, 8'h00);
        rd(2); chk("R3 disabled pending", rd_pending, 1);
        expect_win("R3 disabled loses", 1, 5, 0);

        // R10 and R7: finishing line 9 frees pre-emption
        pulse_done(9);
        rd(9); chk("R10 done clears", rd_active, 0);
        expect_win("R7 idle again", 1, 5, 1);

        // R4: clear pending
        cfg(OP_PEND_CLR, 5, 8'h00);
        rd(5); chk("R4 clear pending", rd_pending, 0);
        expect_win("R4 next winner", 1, 6, 1);

        // R11: hardware request on the top line
        cfg(OP_ENABLE, 15, 8'h01);
        expect_win("R11 before request", 1, 6, 1);
        pulse_irq(15);
        rd(15); chk("R11 pending set", rd_pending, 1);
        expect_win("R11 top line wins", 1, 15, 1);

        wait (exp_q.size() == 0);
        #1;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule